// File: doc/BRIEF.md
# Reread and Rewrite Pointer Controller

This block owns two byte-granular queue pointers on the narrow side of a bidirectional buffer. The first is the read pointer of the outbound queue. The second is the write pointer of the inbound queue. Each pointer has a shadow copy. A block of bytes can be saved at a mark and replayed later: the block is read again by restoring the read pointer, or written again by restoring the write pointer. The memory array and the bus timing live outside this block. The block sees only a per-cycle advance pulse for each pointer.

Software controls the block through 16-bit command words on the wide-side port. The four-bit opcode sits in bits 11:8 and the three-bit operand sits in bits 2:0. Dedicated level inputs can also save and restore the shadows without software.

A small state machine sequences each command:
- **IDLE**: waits for a command. The transition IDLE→EXEC is taken when a command word is accepted.
- **EXEC**: lasts one cycle. In this cycle the latched word is decoded, its pulses are driven and its register effects land at the closing edge. From EXEC the machine goes EXEC→EXEC when another command arrives in that cycle, and EXEC→IDLE otherwise.

Each pointer is `PTR_W` bits wide and wraps modulo 2^`PTR_W`.

Top module: `rrw_ptr_ctrl`

## Requirements
- R1: After reset, all four pointers, `cfg_sel`, `dma_dir`, `stat_fmt` and every pulse output are 0.
- R2: A command word is accepted at a rising edge only when `a_cs_n`=0, `a_addr`=2'b11 and `a_wr`=1. Its effect appears at the outputs after the following edge. That means pulses are high for the single cycle after acceptance, and register effects are visible one cycle after that. An access with any other select, address or write value has no effect.
- R3: Only command bits 11:8 (opcode) and 2:0 (operand) influence behaviour. Bits 15:12 and 7:3 are ignored.
- R4: Opcode 0010 copies `rd_ptr` into `reread_ptr`, and a high `ld_reread` does the same. Opcode 0011 copies `wr_ptr` into `rewrite_ptr`, and a high `ld_rewrite` does the same. All copies use the value the pointer held before that edge.
- R5: Opcode 0100 loads `rd_ptr` from `reread_ptr`, and a low `reread_n` does the same. Opcode 0101 loads `wr_ptr` from `rewrite_ptr`, and a low `rewrite_n` does the same.
- R6: Each cycle, `rd_adv`/`wr_adv` add one to their pointer. Opcodes 1000 and 1001 add one more to `rd_ptr` and `wr_ptr` respectively. Sums wrap modulo 2^`PTR_W`.
- R7: A restore in a cycle overrides any advance or byte increment of the same pointer in that cycle.
- R8: Opcode 1010 raises `clr_wr_par` and opcode 1011 raises `clr_rd_par`. Each is high for exactly the one EXEC cycle of its command.
- R9: Opcode 0001 sets `cfg_sel` to the operand. Opcode 0110 sets `dma_dir` to operand bit 0. Opcode 0111 sets `stat_fmt` to operand bit 0.
- R10: Opcode 0000 raises `rst_pulse` for one cycle, with `rst_scope` equal to the operand (`rst_scope` is 0 otherwise). Operand bit 0 clears `rd_ptr` and `reread_ptr`, and bit 1 clears `wr_ptr` and `rewrite_ptr`. A clear overrides any restore, save or advance in the same cycle.
- R11: Opcodes 1100 to 1111 change no output.
- R12: Commands accepted on consecutive cycles are each executed, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Wide-side select, active low |
| a_addr | input | 2 | Wide-side resource address; 2'b11 is the command word |
| a_wr | input | 1 | Write qualifier for the current access |
| a_data | input | 16 | Command word |
| rd_adv | input | 1 | Narrow-side byte read from the outbound queue |
| wr_adv | input | 1 | Narrow-side byte write into the inbound queue |
| reread_n | input | 1 | Low: restore read pointer from its shadow |
| rewrite_n | input | 1 | Low: restore write pointer from its shadow |
| ld_reread | input | 1 | High: save read pointer into its shadow |
| ld_rewrite | input | 1 | High: save write pointer into its shadow |
| rd_ptr | output | PTR_W | Outbound read pointer |
| wr_ptr | output | PTR_W | Inbound write pointer |
| reread_ptr | output | PTR_W | Shadow of the read pointer |
| rewrite_ptr | output | PTR_W | Shadow of the write pointer |
| clr_wr_par | output | 1 | Pulse: clear write parity error |
| clr_rd_par | output | 1 | Pulse: clear read parity error |
| rst_pulse | output | 1 | Pulse: reset command executing |
| rst_scope | output | 3 | Operand of the executing reset command |
| cfg_sel | output | 3 | Selected configuration register index |
| dma_dir | output | 1 | Narrow-side transfer direction |
| stat_fmt | output | 1 | Status word format |

## Verification
Some cases are hard to reach from the ports because they need several sources to act on one pointer in the same cycle. Examples are a command restore landing while a strobe saves, an advance running and a byte increment executing, or a scoped reset clearing a lane while a strobe tries to restore it. The stimulus reaches these cases by writing the command exactly one cycle before the strobe and advance inputs are applied, so that the command's EXEC cycle coincides with them. A long advance run crosses the wrap point of both pointers. A reference model stepped every clock checks every output in every cycle.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

    localparam logic [3:0] OP_RESET    = 4'h0;
    localparam logic [3:0] OP_CFGSEL   = 4'h1;
    localparam logic [3:0] OP_SAVE_RD  = 4'h2;
    localparam logic [3:0] OP_SAVE_WR  = 4'h3;
    localparam logic [3:0] OP_REST_RD  = 4'h4;
    localparam logic [3:0] OP_REST_WR  = 4'h5;
    localparam logic [3:0] OP_DMADIR   = 4'h6;
    localparam logic [3:0] OP_STATFMT  = 4'h7;
    localparam logic [3:0] OP_INC_RD   = 4'h8;
    localparam logic [3:0] OP_INC_WR   = 4'h9;
    localparam logic [3:0] OP_CLR_WPAR = 4'hA;
    localparam logic [3:0] OP_CLR_RPAR = 4'hB;

    localparam int LANES = 2;
    localparam int LANE_RD = 0;
    localparam int LANE_WR = 1;

    typedef enum logic {
        ST_IDLE,
        ST_EXEC
    } fsm_st_t;

    typedef struct packed {
        logic       reset;
        logic       cfgsel;
        logic [1:0] save;
        logic [1:0] rest;
        logic [1:0] inc;
        logic       dmadir;
        logic       statfmt;
        logic       clr_wpar;
        logic       clr_rpar;
        logic [2:0] operand;
    } cmd_dec_t;

endpackage

// File: rtl/rrw_cmd_fsm.sv
module rrw_cmd_fsm
    import rrw_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CMD_W-1:0] cmd_in,
    output cmd_dec_t         dec
);

    fsm_st_t    state, state_nxt;
    logic [3:0] op_q;
    logic [2:0] od_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (hit) state_nxt = ST_EXEC;
            ST_EXEC: if (!hit) state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= 4'h0;
            od_q  <= 3'h0;
        end else begin
            state <= state_nxt;
            if (hit) begin
                op_q <= cmd_in[11:8];
                od_q <= cmd_in[2:0];
            end
        end
    end

    always_comb begin
        dec = '0;
        unique case (state)
            ST_IDLE: dec = '0;
            ST_EXEC: begin
                dec.operand = od_q;
                case (op_q)
                    OP_RESET:    dec.reset = 1'b1;
                    OP_CFGSEL:   dec.cfgsel = 1'b1;
                    OP_SAVE_RD:  dec.save[LANE_RD] = 1'b1;
                    OP_SAVE_WR:  dec.save[LANE_WR] = 1'b1;
                    OP_REST_RD:  dec.rest[LANE_RD] = 1'b1;
                    OP_REST_WR:  dec.rest[LANE_WR] = 1'b1;
                    OP_DMADIR:   dec.dmadir = 1'b1;
                    OP_STATFMT:  dec.statfmt = 1'b1;
                    OP_INC_RD:   dec.inc[LANE_RD] = 1'b1;
                    OP_INC_WR:   dec.inc[LANE_WR] = 1'b1;
                    OP_CLR_WPAR: dec.clr_wpar = 1'b1;
                    OP_CLR_RPAR: dec.clr_rpar = 1'b1;
                    default:     dec.operand = 3'h0;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/rrw_ptr_unit.sv
module rrw_ptr_unit #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             save,
    input  logic             restore,
    input  logic             adv,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] shadow
);

    logic [PTR_W-1:0] ptr_nxt, shadow_nxt, step;

    always_comb begin
        step = PTR_W'(adv) + PTR_W'(inc);
        if (clr)          ptr_nxt = '0;
        else if (restore) ptr_nxt = shadow;
        else              ptr_nxt = ptr + step;
        if (clr)          shadow_nxt = '0;
        else if (save)    shadow_nxt = ptr;
        else              shadow_nxt = shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            shadow <= '0;
        end else begin
            ptr    <= ptr_nxt;
            shadow <= shadow_nxt;
        end
    end

endmodule

// File: rtl/rrw_mode_regs.sv
module rrw_mode_regs
    import rrw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_dec_t   dec,
    output logic [2:0] cfg_sel,
    output logic       dma_dir,
    output logic       stat_fmt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sel  <= 3'h0;
            dma_dir  <= 1'b0;
            stat_fmt <= 1'b0;
        end else begin
            if (dec.cfgsel)  cfg_sel  <= dec.operand;
            if (dec.dmadir)  dma_dir  <= dec.operand[0];
            if (dec.statfmt) stat_fmt <= dec.operand[0];
        end
    end

endmodule

// File: rtl/rrw_ptr_ctrl.sv
module rrw_ptr_ctrl
    import rrw_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_cs_n,
    input  logic [1:0]       a_addr,
    input  logic             a_wr,
    input  logic [CMD_W-1:0] a_data,
    input  logic             rd_adv,
    input  logic             wr_adv,
    input  logic             reread_n,
    input  logic             rewrite_n,
    input  logic             ld_reread,
    input  logic             ld_rewrite,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] reread_ptr,
    output logic [PTR_W-1:0] rewrite_ptr,
    output logic             clr_wr_par,
    output logic             clr_rd_par,
    output logic             rst_pulse,
    output logic [2:0]       rst_scope,
    output logic [2:0]       cfg_sel,
    output logic             dma_dir,
    output logic             stat_fmt
);

    localparam logic [1:0] CMD_ADDR = 2'b11;

    cmd_dec_t         dec;
    logic             cmd_hit;
    logic [LANES-1:0] l_clr, l_save, l_rest, l_adv;
    logic [PTR_W-1:0] l_ptr [LANES];
    logic [PTR_W-1:0] l_shd [LANES];
    logic             clr_a, restore_a;

    assign cmd_hit = !a_cs_n && a_wr && (a_addr == CMD_ADDR);

    rrw_cmd_fsm #(.CMD_W(CMD_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (cmd_hit),
        .cmd_in (a_data),
        .dec    (dec)
    );

    assign l_clr  = {dec.reset & dec.operand[1], dec.reset & dec.operand[0]};
    assign l_save = dec.save | {ld_rewrite, ld_reread};
    assign l_rest = dec.rest | {~rewrite_n, ~reread_n};
    assign l_adv  = {wr_adv, rd_adv};

    assign clr_a     = l_clr[LANE_RD];
    assign restore_a = l_rest[LANE_RD];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rrw_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (l_clr[g]),
            .save    (l_save[g]),
            .restore (l_rest[g]),
            .adv     (l_adv[g]),
            .inc     (dec.inc[g]),
            .ptr     (l_ptr[g]),
            .shadow  (l_shd[g])
        );
    end

    assign rd_ptr      = l_ptr[LANE_RD];
    assign wr_ptr      = l_ptr[LANE_WR];
    assign reread_ptr  = l_shd[LANE_RD];
    assign rewrite_ptr = l_shd[LANE_WR];

    rrw_mode_regs u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (dec),
        .cfg_sel  (cfg_sel),
        .dma_dir  (dma_dir),
        .stat_fmt (stat_fmt)
    );

    assign clr_wr_par = dec.clr_wpar;
    assign clr_rd_par = dec.clr_rpar;
    assign rst_pulse  = dec.reset;
    assign rst_scope  = dec.reset ? dec.operand : 3'h0;

endmodule

// File: rtl/rrw_ptr_ctrl_chk.sv
module rrw_ptr_ctrl_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_reread,
    input logic             cmd_hit,
    input logic             clr_a,
    input logic             restore_a,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] reread_ptr,
    input logic             clr_wr_par,
    input logic             clr_rd_par,
    input logic             rst_pulse
);

    a_r7_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_a && !clr_a) |=> (rd_ptr == $past(reread_ptr)));

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_reread && !clr_a) |=> (reread_ptr == $past(rd_ptr)));

    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_a && !clr_a) |=> (PTR_W'(rd_ptr - $past(rd_ptr)) <= PTR_W'(2)));

    a_r8_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_wr_par, clr_rd_par, rst_pulse}));

    a_r2_pulse_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_hit |=> !(clr_wr_par || clr_rd_par || rst_pulse));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_a |=> (rd_ptr == '0 && reread_ptr == '0));

endmodule

bind rrw_ptr_ctrl rrw_ptr_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_reread  (ld_reread),
    .cmd_hit    (cmd_hit),
    .clr_a      (clr_a),
    .restore_a  (restore_a),
    .rd_ptr     (rd_ptr),
    .reread_ptr (reread_ptr),
    .clr_wr_par (clr_wr_par),
    .clr_rd_par (clr_rd_par),
    .rst_pulse  (rst_pulse)
);

// File: tb/test_rrw_ptr_ctrl.sv
`timescale 1ns/1ps
module test_rrw_ptr_ctrl;

    localparam int PTR_W = 10;
    localparam int MASK  = (1 << PTR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             a_cs_n = 1'b1;
    logic [1:0]       a_addr = 2'b00;
    logic             a_wr = 1'b0;
    logic [15:0]      a_data = 16'h0;
    logic             rd_adv = 1'b0, wr_adv = 1'b0;
    logic             reread_n = 1'b1, rewrite_n = 1'b1;
    logic             ld_reread = 1'b0, ld_rewrite = 1'b0;
    logic [PTR_W-1:0] rd_ptr, wr_ptr, reread_ptr, rewrite_ptr;
    logic             clr_wr_par, clr_rd_par, rst_pulse, dma_dir, stat_fmt;
    logic [2:0]       rst_scope, cfg_sel;

    rrw_ptr_ctrl #(.PTR_W(PTR_W)) i_rrw_ptr_ctrl (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 0;

    int m_rd = 0, m_wr = 0, m_rrd = 0, m_rwr = 0, m_cfg = 0, m_dma = 0, m_fmt = 0;
    bit m_ev = 0;
    logic [15:0] m_ec = 16'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rd = 0; m_wr = 0; m_rrd = 0; m_rwr = 0;
            m_cfg = 0; m_dma = 0; m_fmt = 0; m_ev = 0; m_ec = 0;
        end else begin
            int op, od, n_rd, n_wr, n_rrd, n_rwr;
            bit ca, cb;
            op = m_ev ? int'(m_ec[11:8]) : -1;
            od = int'(m_ec[2:0]);
            ca = (op == 0) && od[0];
            cb = (op == 0) && od[1];
            n_rd  = ca ? 0 : ((op == 4) || !reread_n) ? m_rrd
                  : (m_rd + int'(rd_adv) + int'(op == 8)) & MASK;
            n_rrd = ca ? 0 : ((op == 2) || ld_reread) ? m_rd : m_rrd;
            n_wr  = cb ? 0 : ((op == 5) || !rewrite_n) ? m_rwr
                  : (m_wr + int'(wr_adv) + int'(op == 9)) & MASK;
            n_rwr = cb ? 0 : ((op == 3) || ld_rewrite) ? m_wr : m_rwr;
            m_rd = n_rd; m_rrd = n_rrd; m_wr = n_wr; m_rwr = n_rwr;
            if (op == 1) m_cfg = od;
            if (op == 6) m_dma = od & 1;
            if (op == 7) m_fmt = od & 1;
            m_ev = !a_cs_n && a_wr && (a_addr == 2'b11);
            m_ec = a_data;
        end
    end

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int op;
            op = m_ev ? int'(m_ec[11:8]) : -1;
            cycles++;
            chk("rd_ptr", int'(rd_ptr), m_rd);
            chk("wr_ptr", int'(wr_ptr), m_wr);
            chk("reread_ptr", int'(reread_ptr), m_rrd);
            chk("rewrite_ptr", int'(rewrite_ptr), m_rwr);
            chk("cfg_sel", int'(cfg_sel), m_cfg);
            chk("dma_dir", int'(dma_dir), m_dma);
            chk("stat_fmt", int'(stat_fmt), m_fmt);
            chk("clr_wr_par", int'(clr_wr_par), int'(op == 10));
            chk("clr_rd_par", int'(clr_rd_par), int'(op == 11));
            chk("rst_pulse", int'(rst_pulse), int'(op == 0));
            chk("rst_scope", int'(rst_scope), (op == 0) ? int'(m_ec[2:0]) : 0);
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                done = 1;
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        a_cs_n = 1; a_wr = 0; a_addr = 2'b00; a_data = 16'h0;
        rd_adv = 0; wr_adv = 0; reread_n = 1; rewrite_n = 1;
        ld_reread = 0; ld_rewrite = 0;
    endtask

    task automatic cmd(logic [3:0] op, logic [2:0] od, logic [15:0] junk);
        step();
        a_cs_n = 0; a_wr = 1; a_addr = 2'b11;
        a_data = (junk & 16'hF0F8) | {4'h0, op, 5'h0, od};
    endtask

    task automatic advance(int n, bit r, bit w);
        for (int i = 0; i < n; i++) begin
            step(); idle(); rd_adv = r; wr_adv = w;
        end
    endtask

    initial begin
        step(); step();
        cur_req = "R1";                      // reset state
        step(); rst_n = 1; idle();
        step();
        cur_req = "R6"; advance(37, 1, 0); advance(23, 0, 1); advance(5, 1, 1);
        cur_req = "R4"; cmd(4'h2, 0, 16'h0); step(); idle(); rd_adv = 1; step(); idle();
        cmd(4'h3, 0, 16'h0); step(); idle();
        advance(9, 1, 1);
        cur_req = "R5"; cmd(4'h4, 0, 16'h0); step(); idle(); step();
        cmd(4'h5, 0, 16'h0); step(); idle(); step();
        advance(4, 1, 1);
        cur_req = "R4"; step(); idle(); ld_reread = 1; ld_rewrite = 1; rd_adv = 1;
        advance(6, 1, 1);
        cur_req = "R5"; step(); idle(); reread_n = 0; rewrite_n = 0;
        step(); idle(); reread_n = 0; rd_adv = 1; step(); idle();
        cur_req = "R7"; advance(3, 1, 1);
        cmd(4'h4, 0, 16'h0); step(); idle(); rd_adv = 1; wr_adv = 1; rewrite_n = 0; step(); idle();
        cmd(4'h8, 0, 16'h0); step(); idle(); reread_n = 0; rd_adv = 1; step(); idle();
        cur_req = "R6"; cmd(4'h8, 0, 16'h0); step(); idle(); rd_adv = 1; step(); idle();
        cmd(4'h9, 0, 16'h0); step(); idle(); wr_adv = 1; step(); idle();
        cur_req = "R8"; cmd(4'hA, 0, 16'h0); step(); idle(); step();
        cmd(4'hB, 0, 16'h0); step(); idle(); step();
        cur_req = "R9"; cmd(4'h1, 3'd5, 16'h0); cmd(4'h6, 3'd1, 16'h0); cmd(4'h7, 3'd3, 16'h0);
        step(); idle(); step(); cmd(4'h1, 3'd2, 16'h0); cmd(4'h6, 3'd6, 16'h0); step(); idle(); step();
        cur_req = "R3"; cmd(4'h1, 3'd7, 16'hFFFF); cmd(4'h7, 3'd1, 16'hA5A5); step(); idle(); step();
        cur_req = "R2";
        step(); a_cs_n = 1; a_wr = 1; a_addr = 2'b11; a_data = 16'h0B00;
        step(); a_cs_n = 0; a_wr = 0; a_addr = 2'b11; a_data = 16'h0A00;
        step(); a_cs_n = 0; a_wr = 1; a_addr = 2'b10; a_data = 16'h0100;
        step(); a_cs_n = 0; a_wr = 1; a_addr = 2'b01; a_data = 16'h0800;
        step(); idle(); step(); step();
        cur_req = "R11"; advance(5, 1, 1);
        cmd(4'hC, 3'd7, 16'h0); cmd(4'hD, 3'd7, 16'h0); cmd(4'hE, 3'd3, 16'h0); cmd(4'hF, 3'd1, 16'h0);
        step(); idle(); step(); step();
        cur_req = "R12"; cmd(4'h8, 0, 16'h0); cmd(4'h8, 0, 16'h0); cmd(4'hB, 0, 16'h0);
        cmd(4'hB, 0, 16'h0); cmd(4'h9, 0, 16'h0); step(); idle(); step(); step();
        cur_req = "R10"; cmd(4'h2, 0, 16'h0); cmd(4'h3, 0, 16'h0); step(); idle();
        advance(7, 1, 1);
        cmd(4'h0, 3'd1, 16'h0); step(); idle(); reread_n = 0; rd_adv = 1; wr_adv = 1; step(); idle();
        advance(3, 1, 1);
        cmd(4'h0, 3'd6, 16'h0); step(); idle(); ld_rewrite = 1; wr_adv = 1; step(); idle();
        cmd(4'h0, 3'd3, 16'h0); step(); idle(); step(); step();
        cur_req = "R6"; advance(1100, 1, 1);
        cur_req = "R7"; cmd(4'h2, 0, 16'h0); advance(40, 1, 0); step(); idle(); reread_n = 0; rd_adv = 1; step(); idle();
        cur_req = "R1"; step(); rst_n = 0; step(); step(); rst_n = 1; step(); step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule